// File: doc/BRIEF.md
# Table-Driven Lazy Modular Multiplier

This block multiplies two polynomial coefficients and reduces the product modulo a small lattice prime. The modulus is picked by a parameter: either 7681 or 12289. Reduction does not use a Montgomery or Barrett step. It uses two small remainder tables whose contents are computed during elaboration.

The result is lazy. It is congruent to the product modulo the prime, but it is not forced below the prime. A later canonical step, or the arithmetic around the block, is expected to absorb the extra range. The block is a three-stage pipeline: multiply, first fold, second fold. It accepts one operand pair per cycle. Its latency and its sequence of operations are the same for every operand value, so it runs in constant time.

In the first fold, bits 16..23 of the product select a remainder that is added to the low 16 product bits. The low part of that sum is kept. Its carry bits are joined with the product's top bits to address the second table. The word read from the second table is added to the kept part, which gives the result.

Top module: `lazy_modmul`

## Requirements
- R1: When `out_valid` is high, `out_res` mod q equals (a·b) mod q, where a and b are the operands accepted with the matching `in_valid`.
- R2: With the default q = 7681, `out_res` never exceeds 2^13 + q − 2 = 15871 and fits in 14 bits. With q = 12289 it never exceeds 2^14 + q − 2 = 28671 and fits in 15 bits. No final subtraction is applied.
- R3: `out_valid` is high in exactly the cycle three rising edges after the edge that sampled `in_valid` high, and low otherwise. The latency does not depend on operand values.
- R4: Operand pairs may arrive on consecutive cycles without a gap. Results leave on consecutive cycles in arrival order.
- R5: While the synchronous, active-high `rst` is sampled high, `out_valid` and `out_res` become 0, and any in-flight operations are discarded.
- R6: When `out_valid` is low, `out_res` keeps its last value. Operand values presented with `in_valid` low do not change it.
- R7: Corner operands are reduced correctly. These include zero, the largest operand (0x3FFF for q = 7681, 0x7FFF for q = 12289), q − 1, and products whose first fold carries past the kept width.
- R8: The second-table index is {carry bits of the first sum above the kept width, product bits 24 and up}, so the carry bits sit above the product's top bits. Each table entry is the remainder of that index's combined weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is present this cycle |
| in_a | input | 14 (q=7681) / 15 (q=12289) | First coefficient |
| in_b | input | 14 (q=7681) / 15 (q=12289) | Second coefficient |
| out_valid | output | 1 | Result is present this cycle |
| out_res | output | 14 (q=7681) / 15 (q=12289) | Lazily reduced product |

## Verification
In the same cycle, the block can accept a new operand pair while an earlier pair's result leaves the last stage. Bursts of back-to-back pairs drive this case. Random valid gaps interleaved with the bursts create every mix of pipeline stages being full or empty.

The bench keeps a three-deep history of what it drove and judges each cycle against it. It checks that the valid flag appears exactly three edges later, that the result is congruent and within its bound, and that the result holds during gaps. Both moduli are instantiated side by side and fed the same stimulus.

// File: rtl/lazy_modmul_pkg.sv
package lazy_modmul_pkg;

  // Width of a fully reduced residue for modulus q.
  function automatic int res_width(input int unsigned q);
    return $clog2(q);
  endfunction

  // Operand width: one bit more than a residue (lazy inputs allowed).
  function automatic int opnd_width(input int unsigned q);
    return $clog2(q) + 1;
  endfunction

  // Remainder word for table `kind` (0: byte at bit 16, 1: fold table).
  function automatic logic [15:0] tbl_entry(input int unsigned q,
                                            input int kind,
                                            input int unsigned idx);
    longint unsigned w;
    longint unsigned top;
    longint unsigned cy;
    int rw;
    int tw;
    rw = $clog2(q);
    tw = 2 * (rw + 1) - 24;
    if (kind == 0) begin
      w = (longint'(idx) << 16) % longint'(q);
    end else begin
      top = longint'(idx) & ((longint'(1) << tw) - 1);
      cy  = longint'(idx) >> tw;
      w   = ((cy << rw) + (top << 24)) % longint'(q);
    end
    return w[15:0];
  endfunction

endpackage

// File: rtl/lazy_modmul_byte_rom.sv
module lazy_modmul_byte_rom
  import lazy_modmul_pkg::*;
#(
  parameter int unsigned MOD_Q = 7681,
  parameter int          KIND  = 0,
  parameter int          LANE  = 0,
  parameter int          AW    = 8,
  parameter int          DW    = 8
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  function automatic logic [DW-1:0] lane_bits(input int unsigned i);
    logic [15:0] e;
    e = tbl_entry(MOD_Q, KIND, i);
    return (LANE == 0) ? e[DW-1:0] : e[8 +: DW];
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = lane_bits(i);
    end
  end

  assign data = mem[addr];
endmodule

// File: rtl/lazy_modmul_table.sv
module lazy_modmul_table #(
  parameter int unsigned MOD_Q = 7681,
  parameter int          KIND  = 0,
  parameter int          AW    = 8,
  parameter int          RW    = 13
) (
  input  logic [AW-1:0] addr,
  output logic [RW-1:0] data
);
  // Low byte lane and high lane share one index; high lane keeps RW-8 bits.
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = (g == 0) ? 8 : RW - 8;
    lazy_modmul_byte_rom #(
      .MOD_Q(MOD_Q), .KIND(KIND), .LANE(g), .AW(AW), .DW(LW)
    ) u_rom (
      .addr(addr),
      .data(data[g*8 +: LW])
    );
  end
endmodule

// File: rtl/lazy_modmul_mul_stage.sv
module lazy_modmul_mul_stage #(
  parameter int OPW = 14,
  parameter int PW  = 28
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_in,
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output logic           v_out,
  output logic [PW-1:0]  prod
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      prod  <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) prod <= PW'(a) * PW'(b);
    end
  end
endmodule

// File: rtl/lazy_modmul_fold_stage.sv
module lazy_modmul_fold_stage #(
  parameter int unsigned MOD_Q = 7681,
  parameter int PW  = 28,
  parameter int RW  = 13,
  parameter int IW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_in,
  input  logic [PW-1:0] prod,
  output logic          v_out,
  output logic [RW-1:0] kept,
  output logic [IW-1:0] idx2
);
  logic [RW-1:0] rem1;
  logic [16:0]   sum1;

  lazy_modmul_table #(.MOD_Q(MOD_Q), .KIND(0), .AW(8), .RW(RW)) u_tab1 (
    .addr(prod[23:16]),
    .data(rem1)
  );

  assign sum1 = 17'(prod[15:0]) + 17'(rem1);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      kept  <= '0;
      idx2  <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        kept <= sum1[RW-1:0];
        idx2 <= {sum1[16:RW], prod[PW-1:24]};
      end
    end
  end
endmodule

// File: rtl/lazy_modmul.sv
module lazy_modmul
  import lazy_modmul_pkg::*;
#(
  parameter int unsigned MOD_Q = 7681
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic [opnd_width(MOD_Q)-1:0]   in_a,
  input  logic [opnd_width(MOD_Q)-1:0]   in_b,
  output logic                           out_valid,
  output logic [res_width(MOD_Q):0]      out_res
);
  localparam int RW     = res_width(MOD_Q);
  localparam int OPW    = opnd_width(MOD_Q);
  localparam int PW     = 2 * OPW;
  localparam int TOP_W  = PW - 24;
  localparam int CY_W   = 17 - RW;
  localparam int IW     = CY_W + TOP_W;

  logic          v1;
  logic [PW-1:0] prod;
  logic          v2;
  logic [RW-1:0] kept;
  logic [IW-1:0] idx2;
  logic [RW-1:0] rem2;

  lazy_modmul_mul_stage #(.OPW(OPW), .PW(PW)) u_mul (
    .clk(clk), .rst(rst), .v_in(in_valid), .a(in_a), .b(in_b),
    .v_out(v1), .prod(prod)
  );

  lazy_modmul_fold_stage #(.MOD_Q(MOD_Q), .PW(PW), .RW(RW), .IW(IW)) u_fold (
    .clk(clk), .rst(rst), .v_in(v1), .prod(prod),
    .v_out(v2), .kept(kept), .idx2(idx2)
  );

  lazy_modmul_table #(.MOD_Q(MOD_Q), .KIND(1), .AW(IW), .RW(RW)) u_tab2 (
    .addr(idx2),
    .data(rem2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= v2;
      if (v2) out_res <= (RW+1)'(kept) + (RW+1)'(rem2);
    end
  end
endmodule

// File: rtl/lazy_modmul_chk.sv
module lazy_modmul_chk #(
  parameter int unsigned MOD_Q = 7681
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [$clog2(MOD_Q):0]     in_a,
  input logic [$clog2(MOD_Q):0]     in_b,
  input logic                       out_valid,
  input logic [$clog2(MOD_Q):0]     out_res
);
  localparam int RW = $clog2(MOD_Q);
  localparam longint unsigned BOUND = (longint'(1) << RW) + longint'(MOD_Q) - 2;

  logic [1:0] settle;
  always_ff @(posedge clk) begin
    if (rst) settle <= 2'd0;
    else if (settle != 2'd3) settle <= settle + 2'd1;
  end

  // R3
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R1
  congruent_chk: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd3 && out_valid) |->
      ((64'(out_res) % 64'(MOD_Q)) ==
       ((64'($past(in_a, 3)) * 64'($past(in_b, 3))) % 64'(MOD_Q))));

  // R2
  bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (64'(out_res) <= BOUND));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_res));

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_res == '0));
endmodule

bind lazy_modmul lazy_modmul_chk #(.MOD_Q(MOD_Q)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_res(out_res)
);

// File: tb/lazy_modmul_bench.sv
`timescale 1ns/1ps
module lazy_modmul_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        iv = 1'b0;
  logic [14:0] ia = '0;
  logic [14:0] ib = '0;
  logic        ov_n, ov_w;
  logic [13:0] or_n;
  logic [14:0] or_w;

  lazy_modmul #(.MOD_Q(7681)) u_lazy_modmul (
    .clk(clk), .rst(rst), .in_valid(iv), .in_a(ia[13:0]), .in_b(ib[13:0]),
    .out_valid(ov_n), .out_res(or_n)
  );

  lazy_modmul #(.MOD_Q(12289)) u_lazy_modmul_wide (
    .clk(clk), .rst(rst), .in_valid(iv), .in_a(ia), .in_b(ib),
    .out_valid(ov_w), .out_res(or_w)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R1";

  bit          hv [3];
  logic [14:0] ha [3];
  logic [14:0] hb [3];
  longint      hold_n = 0;
  longint      hold_w = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expect_mod(input longint a, input longint b, input longint q);
    return (a * b) % q;
  endfunction

  task automatic observe();
    longint an, bn, aw, bw;
    chk(ov_n == hv[2], "R3", ov_n, hv[2]);
    chk(ov_w == hv[2], "R3", ov_w, hv[2]);
    if (hv[2]) begin
      an = longint'(ha[2][13:0]); bn = longint'(hb[2][13:0]);
      aw = longint'(ha[2]);       bw = longint'(hb[2]);
      chk((longint'(or_n) % 7681) == expect_mod(an, bn, 7681), tag,
          longint'(or_n) % 7681, expect_mod(an, bn, 7681));
      chk((longint'(or_w) % 12289) == expect_mod(aw, bw, 12289), tag,
          longint'(or_w) % 12289, expect_mod(aw, bw, 12289));
      chk(longint'(or_n) <= 15871, "R2", or_n, 15871);
      chk(longint'(or_w) <= 28671, "R2", or_w, 28671);
      hold_n = longint'(or_n);
      hold_w = longint'(or_w);
    end else begin
      chk(longint'(or_n) == hold_n, "R6", or_n, hold_n);
      chk(longint'(or_w) == hold_w, "R6", or_w, hold_w);
    end
  endtask

  task automatic step(input bit v, input logic [14:0] x, input logic [14:0] y);
    @(negedge clk);
    observe();
    hv[2] = hv[1]; ha[2] = ha[1]; hb[2] = hb[1];
    hv[1] = hv[0]; ha[1] = ha[0]; hb[1] = hb[0];
    hv[0] = v;     ha[0] = x;     hb[0] = y;
    iv = v; ia = x; ib = y;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; iv = 1'b0;
    repeat (2) @(negedge clk);
    // R5: everything cleared, in-flight work dropped
    chk(!ov_n && or_n == 0, "R5", {ov_n, or_n}, 0);
    chk(!ov_w && or_w == 0, "R5", {ov_w, or_w}, 0);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin hv[i] = 0; ha[i] = '0; hb[i] = '0; end
    hold_n = 0; hold_w = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin hv[i] = 0; ha[i] = '0; hb[i] = '0; end
    repeat (3) @(negedge clk);
    // R5: state out of the initial reset
    chk(!ov_n && or_n == 0, "R5", {ov_n, or_n}, 0);
    chk(!ov_w && or_w == 0, "R5", {ov_w, or_w}, 0);
    rst = 1'b0;

    // R7 and R8: corners, including first-fold carries into the second index
    tag = "R7";
    step(1, 15'h0000, 15'h0000);
    step(1, 15'h7FFF, 15'h7FFF);
    step(1, 15'h7FFF, 15'h0001);
    step(1, 15'h0001, 15'h7FFF);
    step(1, 15'h7FFF, 15'h0000);
    step(1, 15'd7680, 15'd7680);
    step(1, 15'd12288, 15'd12288);
    step(1, 15'h3FFF, 15'h3FFF);
    tag = "R8";
    step(1, 15'h00FF, 15'h0101);
    step(1, 15'h1FFF, 15'h7FFF);
    step(1, 15'h3FFF, 15'h2001);
    for (int i = 0; i < 4; i++) step(0, 15'($urandom), 15'($urandom));

    // R4: long back-to-back burst
    tag = "R4";
    for (int i = 0; i < 40; i++) step(1, 15'($urandom), 15'($urandom));

    // R6: idle with changing operands must not touch the result
    tag = "R6";
    for (int i = 0; i < 8; i++) step(0, 15'($urandom), 15'($urandom));

    // R1: random traffic with random gaps
    tag = "R1";
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, 15'($urandom), 15'($urandom));

    // R5: reset with work in flight
    step(1, 15'h1234, 15'h4321);
    step(1, 15'h7ABC, 15'h0FED);
    do_reset();
    tag = "R5";
    for (int i = 0; i < 4; i++) step(0, 15'($urandom), 15'($urandom));
    tag = "R1";
    for (int i = 0; i < 200; i++)
      step(($urandom % 2) != 0, 15'($urandom), 15'($urandom));
    for (int i = 0; i < 4; i++) step(0, 15'h0, 15'h0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule